// File: doc/BRIEF.md
# Synchronous Channel Update-Period Shadow

This block holds the update period shared by a group of synchronous PWM channels. Software writes a new period through a one-cycle write port into a shadow register. The value in use, the active period, changes only at a safe boundary. A secondary counter counts PWM period-end strobes up to the active period. The shadow moves into the active register only on a strobe that finds the counter equal to the active period. So a change made while the channels run always lands on an update boundary, and the new value governs the periods that follow.

The shadow transfer is allowed only when at least one synchronous channel exists and the update mode selects one of the two modes that use a period-based update. In every other case the written value stays pending until transfers are allowed again. The counter and the update-event pulse keep running in every mode. The PWM counter and the channel outputs are outside this block.

Top module: `supsh_top`

## Requirements
- R1: After reset the active period, the update counter and the update-event output are all zero, and no write is pending.
- R2: A period-end strobe that finds the counter below the active period raises the counter by one. In cycles without a strobe the counter holds its value.
- R3: A period-end strobe that finds the counter equal to the active period returns the counter to zero.
- R4: The update-event output is high for exactly the one cycle after each strobe that finds the counter equal to the active period. This happens in every update mode and whether or not a transfer takes place.
- R5: A write to the shadow never changes the active period in the cycle it lands.
- R6: The shadow transfer is enabled when the mode input equals 1 or 2 and the synchronous-channel-present input is 1. If a write is pending, the counter is at its limit and a strobe arrives, the active period takes the shadow value in the next cycle.
- R7: When several writes arrive between two transfers, only the last written value reaches the active period.
- R8: With mode 0 or 3, or with the synchronous-channel-present input low, no transfer happens. The pending value is kept and moves at the first limit strobe after transfers are enabled again.
- R9: A limit strobe with no write pending leaves the active period unchanged.
- R10: A write in the same cycle as a transfer does not alter that transfer, which moves the previously held value. The new value stays pending for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_end_i | input | 1 | One-cycle strobe at the end of each PWM period |
| upd_mode_i | input | 2 | Update mode; 1 and 2 enable the shadow transfer |
| sync_present_i | input | 1 | High when at least one synchronous channel is configured |
| wr_en_i | input | 1 | Write strobe for the shadow register |
| wr_data_i | input | PER_W | Value written to the shadow register |
| active_period_o | output | PER_W | Update period in use |
| upd_count_o | output | PER_W | Current count of PWM periods within the update period |
| upd_event_o | output | 1 | One-cycle pulse after each limit strobe |

## Verification
All three outputs are registered, so every result is due exactly one clock edge after the stimulus that causes it. The counter step, the wrap, the event pulse and the active-period change all appear one edge after the strobe or write. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs at the next falling edge. It holds the inputs idle between stimuli, so a late or early change shows up as a miscompare on a specific edge. The event pulse is checked again one idle cycle later to confirm that it has fallen.

// File: rtl/supsh_pkg.sv
package supsh_pkg;

   // Update mode encoding; two of the four codes use period-based update.
   typedef enum logic [1:0] {
      UPM_SOFT   = 2'd0,
      UPM_SEMI   = 2'd1,
      UPM_TIMED  = 2'd2,
      UPM_RSVD   = 2'd3
   } upd_mode_e;

   function automatic logic xfer_allowed(input upd_mode_e mode, input logic sync_present);
      return sync_present && ((mode == UPM_SEMI) || (mode == UPM_TIMED));
   endfunction

endpackage

// File: rtl/supsh_counter.sv
module supsh_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] count_o,
   output logic         hit_o
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         at_limit;

   assign at_limit = (cnt_q == limit_i);
   assign hit_o    = tick_i && at_limit;
   assign count_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= at_limit ? '0 : cnt_q + ONE;
   end

   AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit_i); // R3

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !at_limit) |=> (cnt_q == $past(cnt_q) + ONE)); // R2

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/supsh_shadow.sv
module supsh_shadow #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         take_i,
   output logic [W-1:0] shadow_o,
   output logic         pending_o
);

   logic [W-1:0] shd_q;
   logic         pend_q;

   assign shadow_o  = shd_q;
   assign pending_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr_en_i)
            shd_q <= wr_data_i;
         if (wr_en_i)
            pend_q <= 1'b1;
         else if (take_i)
            pend_q <= 1'b0;
      end
   end

   AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> pend_q); // R10

   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !wr_en_i) |=> !pend_q); // R6

endmodule

// File: rtl/supsh_event.sv
module supsh_event #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   output logic event_o
);

   generate
      if (REG_OUT) begin : g_reg
         logic evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= hit_i;
         end
         assign event_o = evt_q;

         AST_EVENT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i |=> event_o); // R4
         AST_EVENT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_i |=> !event_o); // R4
      end else begin : g_comb
         assign event_o = hit_i;
      end
   endgenerate

endmodule

// File: rtl/supsh_top.sv
module supsh_top
   import supsh_pkg::*;
#(
   parameter int PER_W     = 4,
   parameter bit EVENT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_end_i,
   input  logic [1:0]       upd_mode_i,
   input  logic             sync_present_i,
   input  logic             wr_en_i,
   input  logic [PER_W-1:0] wr_data_i,
   output logic [PER_W-1:0] active_period_o,
   output logic [PER_W-1:0] upd_count_o,
   output logic             upd_event_o
);

   generate
      if (PER_W < 1 || PER_W > 16) begin : g_bad_width
         $error("supsh_top: PER_W must lie in 1..16");
      end
   endgenerate

   logic [PER_W-1:0] act_q;
   logic [PER_W-1:0] shadow;
   logic             pending;
   logic             hit;
   logic             allowed;
   logic             xfer;

   assign allowed = xfer_allowed(upd_mode_e'(upd_mode_i), sync_present_i);
   assign xfer    = hit && allowed && pending;

   supsh_counter #(.W(PER_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (period_end_i),
      .limit_i (act_q),
      .count_o (upd_count_o),
      .hit_o   (hit)
   );

   supsh_shadow #(.W(PER_W)) u_shd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .take_i    (xfer),
      .shadow_o  (shadow),
      .pending_o (pending)
   );

   supsh_event #(.REG_OUT(EVENT_REG)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit),
      .event_o (upd_event_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= '0;
      else if (xfer)
         act_q <= shadow;
   end

   assign active_period_o = act_q;

   AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && allowed && pending) |=> $stable(active_period_o)); // R5

   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !allowed |=> $stable(active_period_o)); // R8

   AST_XFER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (upd_count_o == '0)); // R3

   AST_XFER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (active_period_o == $past(shadow))); // R6

endmodule

// File: tb/supsh_top_bench.sv
`timescale 1ns/1ps
module supsh_top_bench;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         period_end_i = 1'b0;
   logic [1:0]   upd_mode_i = 2'd1;
   logic         sync_present_i = 1'b1;
   logic         wr_en_i = 1'b0;
   logic [W-1:0] wr_data_i = '0;
   logic [W-1:0] active_period_o;
   logic [W-1:0] upd_count_o;
   logic         upd_event_o;

   int n_vec  = 0;
   int n_fail = 0;

   // reference state, derived from the requirements
   logic [W-1:0] m_act = '0, m_cnt = '0, m_shd = '0;
   logic         m_pend = 1'b0, m_evt = 1'b0;

   always #2.5 clk = ~clk;

   supsh_top #(.PER_W(W)) u_supsh_top (
      .clk(clk), .rst_n(rst_n), .period_end_i(period_end_i),
      .upd_mode_i(upd_mode_i), .sync_present_i(sync_present_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .active_period_o(active_period_o), .upd_count_o(upd_count_o),
      .upd_event_o(upd_event_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "active", int'(active_period_o), int'(m_act));
      chk(req, "count",  int'(upd_count_o),     int'(m_cnt));
      chk(req, "event",  int'(upd_event_o),     int'(m_evt));
   endtask

   // One cycle: drive at a falling edge, let the rising edge act, check at the next falling edge.
   task automatic step(input logic pe, input logic we, input logic [W-1:0] d, input string req);
      logic hit, en, xf;
      period_end_i = pe;
      wr_en_i      = we;
      wr_data_i    = d;
      hit = pe && (m_cnt == m_act);
      en  = sync_present_i && (upd_mode_i == 2'd1 || upd_mode_i == 2'd2);
      xf  = hit && en && m_pend;
      m_evt = hit;
      if (pe) m_cnt = hit ? '0 : m_cnt + 1'b1;
      if (xf) m_act = m_shd;
      if (we) begin m_shd = d; m_pend = 1'b1; end
      else if (xf) m_pend = 1'b0;
      @(posedge clk);
      @(negedge clk);
      period_end_i = 1'b0;
      wr_en_i      = 1'b0;
      chk_all(req);
   endtask

   task automatic idle(input string req);
      step(1'b0, 1'b0, '0, req);
   endtask

   task automatic run_to_wrap(input string req);
      for (int i = 0; i < 20; i++) begin
         logic last;
         last = (m_cnt == m_act);
         step(1'b1, 1'b0, '0, req);
         if (last) break;
      end
   endtask

   task automatic t_reset;
      @(negedge clk); @(negedge clk);
      chk_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1");
      // limit strobe right after reset: nothing pending, active stays zero
      step(1'b1, 1'b0, '0, "R1");
      chk("R1", "no pending after reset", int'(active_period_o), 0);
   endtask

   task automatic t_zero_period;
      step(1'b1, 1'b0, '0, "R3");
      step(1'b1, 1'b0, '0, "R4");
      idle("R4");
      chk("R4", "event falls", int'(upd_event_o), 0);
   endtask

   task automatic t_first_load;
      step(1'b0, 1'b1, 4'd3, "R5");
      chk("R5", "write alone", int'(active_period_o), 0);
      idle("R5");
      step(1'b1, 1'b0, '0, "R6");
      chk("R6", "loaded", int'(active_period_o), 3);
   endtask

   task automatic t_counting;
      step(1'b1, 1'b0, '0, "R2");
      idle("R2");
      idle("R2");
      step(1'b1, 1'b0, '0, "R2");
      step(1'b1, 1'b0, '0, "R2");
      chk("R2", "count at limit", int'(upd_count_o), 3);
      step(1'b1, 1'b0, '0, "R3");
      chk("R3", "wrapped", int'(upd_count_o), 0);
      chk("R9", "kept without write", int'(active_period_o), 3);
      chk("R4", "event at wrap", int'(upd_event_o), 1);
      idle("R4");
   endtask

   task automatic t_last_wins;
      step(1'b0, 1'b1, 4'd5, "R7");
      step(1'b1, 1'b1, 4'd7, "R7");
      step(1'b0, 1'b1, 4'd2, "R7");
      run_to_wrap("R7");
      chk("R7", "last write", int'(active_period_o), 2);
   endtask

   task automatic t_gated;
      upd_mode_i = 2'd0;
      step(1'b0, 1'b1, 4'd6, "R8");
      run_to_wrap("R8");
      chk("R8", "mode 0 blocks", int'(active_period_o), 2);
      upd_mode_i = 2'd3;
      run_to_wrap("R8");
      chk("R8", "mode 3 blocks", int'(active_period_o), 2);
      upd_mode_i = 2'd2;
      sync_present_i = 1'b0;
      run_to_wrap("R8");
      chk("R8", "no sync blocks", int'(active_period_o), 2);
      sync_present_i = 1'b1;
      run_to_wrap("R8");
      chk("R8", "released", int'(active_period_o), 6);
   endtask

   task automatic t_collide;
      upd_mode_i = 2'd1;
      step(1'b0, 1'b1, 4'd1, "R10");
      for (int i = 0; i < 20; i++) begin
         if (m_cnt == m_act) break;
         step(1'b1, 1'b0, '0, "R10");
      end
      step(1'b1, 1'b1, 4'd4, "R10");
      chk("R10", "old value moved", int'(active_period_o), 1);
      run_to_wrap("R10");
      chk("R10", "new value next", int'(active_period_o), 4);
      run_to_wrap("R9");
      chk("R9", "stays", int'(active_period_o), 4);
   endtask

   initial begin
      t_reset();
      t_zero_period();
      t_first_load();
      t_counting();
      t_last_wins();
      t_gated();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule